// File: doc/BRIEF.md
# Serial Time-of-Day Sync Master

This block is the sending end of a three-wire time-distribution link. From a fast system clock it makes a bit clock and a heartbeat, and the heartbeat is locked to that bit clock. Once in each heartbeat period it sends a 97-bit time code serially, most significant bit first. The code holds a lock flag, the time of day that applies to the current heartbeat period (seconds and nanoseconds), and a quality value.

A local time-of-day source drives the parallel lock, seconds, nanoseconds and quality inputs. The block takes a copy of these inputs at each heartbeat, so a frame cannot change while it is being sent. All three link signals are outputs only. When the enable input is low, all three outputs stay low and the dividers start again from zero.

With the default parameters and a 100 MHz system clock, the bit clock runs at 10 MHz and the heartbeat at 4 kHz.

Top module: `tod_sync_master`

## Requirements
- R1: The bit clock has a period of 2*HALF_DIV system clocks. It is high for HALF_DIV clocks and low for HALF_DIV clocks, which gives 10 MHz from 100 MHz with the default settings.
- R2: The heartbeat goes high at the same system clock edge as a bit-clock rising edge. It stays high for exactly one bit-clock cycle and repeats every HB_DIV (2500) bit-clock cycles.
- R3: The time code is 97 bits long and is sent MSB first in this order: lock (1 bit), seconds (48 bits), nanoseconds (32 bits), quality (16 bits). The first bit is the value on the line at the bit-clock rising edge that follows the rising edge where the heartbeat went high. Each later bit is on the line at the next rising edge.
- R4: The time-code line changes only at system clock edges where the bit clock falls.
- R5: The time-code line is low at all of the remaining 2403 bit-clock rising edges of each heartbeat period.
- R6: The lock, seconds, nanoseconds and quality inputs are copied only at the heartbeat rising edge. Changing them after that edge has no effect on the frame being sent.
- R7: While enable is low, the heartbeat, bit clock and time code are all low. After enable rises, the first bit-clock rising edge comes HALF_DIV system clocks later, and the heartbeat goes high on that same edge.
- R8: While reset is asserted, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the outputs are held low and the dividers are cleared |
| lock_in | input | 1 | Lock flag from the time source |
| sec_in | input | 48 | Seconds part of the time of day |
| ns_in | input | 32 | Nanoseconds part of the time of day |
| qual_in | input | 16 | Quality value for the time of day |
| hb_out | output | 1 | Heartbeat |
| bclk_out | output | 1 | Bit clock |
| tc_out | output | 1 | Serial time code |

## Verification
The assertions assume that reset is applied from time zero. They also assume that enable is a synchronous level driven in the system clock domain. The bench drives reset and enable only between clock edges. Once reset is released, the parallel time inputs are not constrained at all. The stimulus deliberately changes them in the middle of a frame, so that the capture at the heartbeat is what gets tested. Enable is dropped once, while the line is idle, and then raised again, so that the restart latency can be measured.

// File: rtl/tod_sync_master.sv
module tod_sync_master #(
  parameter int HALF_DIV = 5,
  parameter int HB_DIV   = 2500,
  parameter int SEC_W    = 48,
  parameter int NS_W     = 32,
  parameter int Q_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lock_in,
  input  logic [SEC_W-1:0] sec_in,
  input  logic [NS_W-1:0]  ns_in,
  input  logic [Q_W-1:0]   qual_in,
  output logic             hb_out,
  output logic             bclk_out,
  output logic             tc_out
);

  localparam int WORD_W = 1 + SEC_W + NS_W + Q_W;
  localparam int HW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW     = $clog2(HB_DIV);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(HB_DIV - 1);
  localparam logic [BW-1:0] NBITS     = BW'(WORD_W);

  logic [HW-1:0]     half_q;
  logic [BW-1:0]     bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              bclk_q, hb_q, tc_q;

  wire tick     = (half_q == HALF_LAST);
  wire rise     = tick && !bclk_q;
  wire fall     = tick && bclk_q;
  wire last_bit = (bit_q == BIT_LAST);
  wire in_frame = (bit_q < NBITS);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      half_q <= '0;
      bclk_q <= 1'b0;
      bit_q  <= BIT_LAST;
      hb_q   <= 1'b0;
      tc_q   <= 1'b0;
      sh_q   <= '0;
    end else begin
      half_q <= tick ? '0 : half_q + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (rise) begin
        bit_q <= last_bit ? '0 : bit_q + 1'b1;
        hb_q  <= last_bit;
        if (last_bit) sh_q <= {lock_in, sec_in, ns_in, qual_in};
      end
      if (fall) begin
        if (in_frame) begin
          tc_q <= sh_q[WORD_W-1];
          sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end else begin
          tc_q <= 1'b0;
        end
      end
    end
  end

  assign hb_out   = hb_q;
  assign bclk_out = bclk_q;
  assign tc_out   = tc_q;

endmodule

// File: rtl/tod_sync_master_chk.sv
module tod_sync_master_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic hb_out,
  input logic bclk_out,
  input logic tc_out
);

  a_r4_tc_on_fall: assert property (@(posedge clk) disable iff (rst)
    (tc_out != $past(tc_out)) |-> ($past(bclk_out) && !bclk_out));

  a_r2_hb_rise_with_bclk: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_out) |-> $rose(bclk_out));

  a_r2_hb_fall_with_bclk: assert property (@(posedge clk) disable iff (rst)
    $fell(hb_out) |-> ($rose(bclk_out) || !$past(en)));

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hb_out && !bclk_out && !tc_out));

  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> (!hb_out && !bclk_out && !tc_out));

endmodule

bind tod_sync_master tod_sync_master_chk u_chk (.*);

// File: tb/tb_tod_sync_master.sv
module tb_tod_sync_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 5;
  localparam int HB_DIV     = 2500;
  localparam int WORD_W     = 97;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic        lock_in = 1'b0;
  logic [47:0] sec_in  = '0;
  logic [31:0] ns_in   = '0;
  logic [15:0] qual_in = '0;
  logic hb_out, bclk_out, tc_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_sync_master dut (
    .clk(clk), .rst(rst), .en(en),
    .lock_in(lock_in), .sec_in(sec_in), .ns_in(ns_in), .qual_in(qual_in),
    .hb_out(hb_out), .bclk_out(bclk_out), .tc_out(tc_out)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [WORD_W-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic l, input logic [47:0] s,
                           input logic [31:0] n, input logic [15:0] q);
    lock_in = l; sec_in = s; ns_in = n; qual_in = q;
    exp_q.push_back({l, s, n, q});
  endtask

  // monitor state
  logic prev_bclk = 1'b0, prev_tc = 1'b0;
  bit   collecting = 0, have_hb = 0;
  int   idx = 0, rises_since_hb = 0, idle_err = 0;
  int   sys_since_rise = 0, have_rise = 0, r1_err = 0, r4_err = 0;
  int   frames_done = 0;
  logic [WORD_W-1:0] got;

  always @(negedge clk) begin
    if (rst || !en) begin
      collecting = 0; have_hb = 0; have_rise = 0;
      prev_bclk = bclk_out; prev_tc = tc_out;
    end else begin
      sys_since_rise++;
      if (tc_out != prev_tc && !(prev_bclk && !bclk_out)) r4_err++;
      if (bclk_out && !prev_bclk) begin
        if (have_rise && sys_since_rise != 2*HALF_DIV) r1_err++;
        have_rise = 1; sys_since_rise = 0;
        if (hb_out) begin
          if (have_hb) begin
            check(rises_since_hb == HB_DIV - 1, "R2", "heartbeat period in bit cycles",
                  rises_since_hb + 1, HB_DIV);
            check(idle_err == 0, "R5", "idle rises with time code high", idle_err, 0);
          end
          have_hb = 1; rises_since_hb = 0; idle_err = 0;
          collecting = 1; idx = 0;
        end else begin
          rises_since_hb++;
          if (collecting) begin
            got[WORD_W-1-idx] = tc_out;
            idx++;
            if (idx == WORD_W) begin
              collecting = 0;
              if (exp_q.size() == 0)
                check(0, "R3", "frame with nothing expected", got, 0);
              else begin
                logic [WORD_W-1:0] e;
                e = exp_q.pop_front();
                check(got == e, "R3 R6", "time code word", got, e);
              end
              frames_done++;
            end
          end else if (have_hb && tc_out) idle_err++;
        end
      end
      prev_bclk = bclk_out; prev_tc = tc_out;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int low_err;
    send_word(1'b1, 48'h0000_6543_21AB, 32'h1234_5678, 16'h00A5);
    repeat (4) @(negedge clk);
    check(!hb_out && !bclk_out && !tc_out, "R8", "outputs in reset",
          {hb_out, bclk_out, tc_out}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!hb_out && !bclk_out && !tc_out, "R7", "outputs while disabled",
          {hb_out, bclk_out, tc_out}, 0);
    en = 1'b1;
    // each new word is applied mid-frame; the frame in flight must keep its old word
    wait (hb_out); wait (!hb_out);
    repeat (20) @(negedge clk);
    send_word(1'b0, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    wait (hb_out); wait (!hb_out);
    repeat (20) @(negedge clk);
    send_word(1'b1, 48'hAAAA_5555_AAAA, 32'h5555_AAAA, 16'h8001);
    wait (hb_out); wait (!hb_out);
    repeat (20) @(negedge clk);
    send_word(1'b0, 48'h0000_0000_0001, 32'h8000_0000, 16'h0000);
    wait (frames_done == 4);
    repeat (50) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    low_err = 0;
    repeat (40) begin
      @(negedge clk);
      if (hb_out || bclk_out || tc_out) low_err++;
    end
    check(low_err == 0, "R7", "cycles with an output high while disabled", low_err, 0);
    exp_q.push_back({lock_in, sec_in, ns_in, qual_in});
    en = 1'b1;
    repeat (HALF_DIV - 1) @(negedge clk);
    check(!hb_out && !bclk_out, "R7", "no edge before restart latency",
          {hb_out, bclk_out}, 0);
    @(negedge clk);
    check(hb_out && bclk_out, "R7", "heartbeat on first bit-clock rise",
          {hb_out, bclk_out}, 2'b11);
    wait (frames_done == 5);
    repeat (20) @(negedge clk);
    check(r1_err == 0, "R1", "bit-clock periods of wrong length", r1_err, 0);
    check(r4_err == 0, "R4", "time-code changes off a falling edge", r4_err, 0);
    check(exp_q.size() == 0, "R3", "expected words left over", exp_q.size(), 0);
    finish_run();
  end
endmodule